// File: doc/BRIEF.md
# Hobby Servo Pulse Generator

This block drives the control line of a hobby servo. It produces a pulse that repeats once per frame. An 8-bit position value sets how long each pulse stays high. The pulse has a fixed floor of about 1 ms, and each position step adds about 3.9 us, so the widest pulse is just under 2 ms. The frame lasts about 16 ms. This is much longer than the pulse range, which is what a servo expects. A plain PWM, whose period equals its count range, does not behave this way.

A prescaler divides the 50 MHz system clock by a parameter, which defaults to 195. Each time the prescaler completes a count it produces a one-cycle tick, roughly every 3.9 us. A free-running 12-bit frame counter advances on each tick and rolls over to zero when it passes its largest value. The pulse stays high while the frame counter is below a threshold. The threshold is the held position with a single set bit placed just above it.

The position is sampled only at frame rollover, so a pulse that has already started always finishes at the width it began with. The position is a level input with no handshake, because the block accepts a new value once per frame.

Top module: `servo_pulse_gen`

## Requirements
- R1: The prescaler emits a one-cycle tick on every DIV-th clock and its count returns to zero on the tick cycle, so ticks are exactly DIV clocks apart (DIV defaults to 195).
- R2: The frame counter (FRAME_W bits, default 12) advances by one on each tick and holds its value on every other clock.
- R3: The frame counter wraps from all ones to zero, so consecutive pulse rising edges are exactly DIV * 2^FRAME_W clocks apart.
- R4: The compare threshold is 2^POS_W plus the held position, which means bit POS_W is set and every higher bit is clear. The output is high exactly while the frame counter is below the threshold, so one pulse lasts (2^POS_W + position) * DIV clocks and starts when the frame counter is zero.
- R5: Position 0 gives the shortest pulse, 2^POS_W * DIV clocks (1 ms at the defaults). The all-ones position gives the longest pulse, (2^(POS_W+1) - 1) * DIV clocks.
- R6: The position input is sampled only on the clock edge where the frame counter wraps to zero. Changes at any other time have no effect on the pulse in progress.
- R7: Synchronous reset clears the prescaler, the frame counter and the held position. The output stays low until the first rollover, which comes DIV * 2^FRAME_W clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| position | input | POS_W (8) | Requested servo position, sampled at frame rollover |
| servo_out | output | 1 | Servo control pulse |

## Verification
The results are due at fixed edge counts. The first rising edge comes DIV * 2^FRAME_W edges after reset is released. The pulse then stays high for (2^POS_W + p) * DIV edges, where p is the position present at the rollover edge. The next rising edge follows exactly one frame later. The bench runs with a small divisor and narrow counters so that many frames fit in the run. It samples the output 1 ns after every rising clock edge and counts edges from each event, so every width and period is compared as an exact clock count. The position is changed only while a pulse is high, including a temporary junk value. Each width therefore tests that the value taken at rollover, and only that value, is used.

// File: rtl/servo_pkg.sv
package servo_pkg;
  localparam int unsigned DEF_DIV     = 195;
  localparam int unsigned DEF_FRAME_W = 12;
  localparam int unsigned DEF_POS_W   = 8;

  // width needed to hold the values 0 .. n-1, at least one bit
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/servo_tick_div.sv
module servo_tick_div
  import servo_pkg::*;
#(
  parameter int unsigned DIV = DEF_DIV
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = cnt_width(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R1: count restarts on the tick cycle
  a_r1_restart: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == '0));
  // R1: count climbs by one between ticks
  a_r1_advance: assert property (@(posedge clk) disable iff (rst)
    !tick |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/servo_frame_ctr.sv
module servo_frame_ctr
  import servo_pkg::*;
#(
  parameter int unsigned FRAME_W = DEF_FRAME_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  output logic [FRAME_W-1:0] frame,
  output logic               wrap
);
  assign wrap = tick && (frame == '1);

  always_ff @(posedge clk) begin
    if (rst)       frame <= '0;
    else if (tick) frame <= frame + 1'b1;
  end

  // R2: one step per tick
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> (frame == $past(frame) + 1'b1));
  // R2: no motion without a tick
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(frame));
  // R3: rollover lands on zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (frame == '0));
endmodule

// File: rtl/servo_pos_hold.sv
module servo_pos_hold
  import servo_pkg::*;
#(
  parameter int unsigned FRAME_W = DEF_FRAME_W,
  parameter int unsigned POS_W   = DEF_POS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrap,
  input  logic [POS_W-1:0]   position,
  input  logic [FRAME_W-1:0] frame,
  output logic               pulse
);
  localparam logic [FRAME_W-1:0] BASE = FRAME_W'(1) << POS_W;

  logic [POS_W-1:0]   held;
  logic               armed;
  logic [FRAME_W-1:0] thresh;

  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= '0;
      armed <= 1'b0;
    end else if (wrap) begin
      held  <= position;
      armed <= 1'b1;
    end
  end

  assign thresh = BASE + FRAME_W'(held);
  assign pulse  = armed && (frame < thresh);

  // R6: held value changes only at rollover
  a_r6_keep: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(held));
  // R6: rollover takes the live input
  a_r6_take: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (held == $past(position)));
  // R7: arming happens only as a frame starts
  a_r7_arm_at_start: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> (frame == '0));
endmodule

// File: rtl/servo_pulse_gen.sv
module servo_pulse_gen
  import servo_pkg::*;
#(
  parameter int unsigned DIV     = DEF_DIV,
  parameter int unsigned FRAME_W = DEF_FRAME_W,
  parameter int unsigned POS_W   = DEF_POS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] position,
  output logic             servo_out
);
  localparam logic [FRAME_W-1:0] FLOOR = FRAME_W'(1) << POS_W;

  logic               tick;
  logic               wrap;
  logic [FRAME_W-1:0] frame;

  initial begin
    a_cfg: assert (DIV >= 2 && POS_W + 1 <= FRAME_W);
  end

  servo_tick_div #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  servo_frame_ctr #(.FRAME_W(FRAME_W)) u_frame (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .frame (frame),
    .wrap  (wrap)
  );

  servo_pos_hold #(.FRAME_W(FRAME_W), .POS_W(POS_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .wrap     (wrap),
    .position (position),
    .frame    (frame),
    .pulse    (servo_out)
  );

  // R4: pulses begin only at frame start
  a_r4_rise_at_start: assert property (@(posedge clk) disable iff (rst)
    $rose(servo_out) |-> (frame == '0));
  // R5: no pulse ends before the fixed floor
  a_r5_floor: assert property (@(posedge clk) disable iff (rst)
    $fell(servo_out) |-> (frame >= FLOOR));
endmodule

// File: tb/sim_servo_pulse_gen.sv
module sim_servo_pulse_gen;
  localparam int unsigned DIV     = 4;
  localparam int unsigned FRAME_W = 9;
  localparam int unsigned POS_W   = 6;
  localparam int unsigned PERIOD  = DIV * (1 << FRAME_W);
  localparam int unsigned PMAX    = (1 << POS_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [POS_W-1:0] position = '0;
  logic             servo_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  servo_pulse_gen #(.DIV(DIV), .FRAME_W(FRAME_W), .POS_W(POS_W)) u0 (
    .clk       (clk),
    .rst       (rst),
    .position  (position),
    .servo_out (servo_out)
  );

  function automatic int exp_width(input int p);
    return ((1 << POS_W) + p) * DIV;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // count edges until the output rises; returns edge count
  task automatic wait_rise(output int n, output int low_seen_high);
    n = 0;
    low_seen_high = 0;
    do begin
      step();
      n++;
    end while (!servo_out && n < 3 * PERIOD);
  endtask

  // measure high time starting at a sample where the output is high,
  // optionally swapping the position while high; returns samples high
  task automatic measure_high(input logic [POS_W-1:0] junk,
                              input logic [POS_W-1:0] next_pos,
                              output int width);
    width = 1;
    position = junk;
    for (int i = 0; i < 8; i++) begin
      step();
      if (servo_out) width++;
      else return;
    end
    position = next_pos;
    while (servo_out && width < 3 * PERIOD) begin
      step();
      if (servo_out) width++;
    end
  endtask

  // one full frame: pulse just rose with cur_pos captured
  task automatic frame(input int cur_pos, input logic [POS_W-1:0] next_pos,
                       input string tag);
    int w, n, dummy;
    measure_high(~next_pos, next_pos, w);
    check({tag, " width"}, w, exp_width(cur_pos));
    wait_rise(n, dummy);
    check("R3 frame period", n + w, PERIOD);
  endtask

  initial begin
    int n, dummy, cur, nxt, w;
    void'($urandom(32'd1234));
    position = 6'd0;
    for (int i = 0; i < 4; i++) begin
      step();
      check("R7 low in reset", servo_out, 0);
    end
    rst = 1'b0;
    // R7: no pulse until first rollover, which comes one frame later
    wait_rise(n, dummy);
    check("R7 first rise", n, PERIOD);
    // R5 min width, then R5 max, R6 via junk swaps, R4 directed
    cur = 0;
    frame(cur, 6'(PMAX), "R5 min");
    cur = PMAX;
    frame(cur, 6'd1, "R5 max");
    cur = 1;
    frame(cur, 6'd32, "R4 pos1");
    cur = 32;
    // R1/R2/R4/R6 random positions, junk applied mid-pulse each time
    for (int k = 0; k < 8; k++) begin
      nxt = $urandom_range(PMAX, 0);
      frame(cur, 6'(nxt), "R6 random");
      cur = nxt;
    end
    // R7: reset mid-pulse clears output and restarts frame timing
    measure_high(6'd5, 6'd5, w);
    wait_rise(n, dummy);
    rst = 1'b1;
    step();
    check("R7 reset mid-pulse low", servo_out, 0);
    step();
    rst = 1'b0;
    position = 6'd20;
    wait_rise(n, dummy);
    check("R7 rise after reset", n, PERIOD);
    frame(20, 6'd0, "R4 after reset");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule